// File: doc/BRIEF.md
# DRAM Access Controller with Refresh Scheduler

This block sits between a host that issues single-bit reads and writes and the pins of a 4096 x 1 dynamic memory. A host request carries a 12-bit address, a write flag and one data bit. The request is accepted through a valid/ready handshake, and each read returns its bit with a one-cycle valid pulse. The controller splits the address into a row half and a column half. It presents the two halves one after the other on a 6-bit multiplexed address bus, and it sequences the active-low row strobe, column strobe and write enable so that both halves are latched by the memory.

A free-running interval counter raises a refresh request every `REF_INTERVAL` clocks. At 50 MHz the default of 3125 gives 62.5 µs per row, so all 64 rows are covered in 4 ms. A refresh that comes due waits only for an access already in progress, and it is always served before the next host request. A static mode input selects the refresh style:
- Row-strobe-only refresh: the controller keeps its own row counter and drives it on the bus.
- Column-before-row refresh: the column strobe falls first and the memory tracks the row itself.

Every strobe width and precharge time is a parameter given in clock counts.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: The row is taken from address bits [11:6] and the column from bits [5:0]. The row is on the bus in the cycle before the row strobe falls and stays there while it falls. The column is on the bus in the cycle before the column strobe falls and stays there while it falls.
- R2: A read produces exactly one `rsp_valid_o` pulse, one clock wide, carrying the memory output sampled at the end of the column-low time. A write produces no pulse.
- R3: For a write, the write enable is low before the column strobe falls and stays stable while the column strobe is low. In every access, the row strobe rises while the column strobe is still low, and the column strobe rises after it.
- R4: A refresh is requested every `REF_INTERVAL` clocks. With no host traffic, successive refresh starts are exactly `REF_INTERVAL` clocks apart. Under traffic they stay within one access length of that spacing.
- R5: With `cbr_mode_i`=0, a refresh drives the internal row counter on the bus and holds the row strobe low for `T_RAS` clocks with the column strobe high. The counter is 0 after reset, advances by one per refresh, and wraps from 63 to 0.
- R6: With `cbr_mode_i`=1, a refresh lowers the column strobe one clock before the row strobe, drives address 0, and holds the row strobe low for `T_RAS` clocks. The column strobe falls first only in this mode, and the row strobe never falls alone to refresh in it.
- R7: While a refresh is pending or running, `req_ready_o` is low and both strobes are high whenever ready is high. A pending refresh runs after the current access and before the next host request.
- R8: An access holds the row strobe low for `T_RCD`+1 clocks before the column strobe falls, and holds the column strobe low for `T_CAS`+1 clocks. The row strobe stays high for at least `T_RP` clocks between any two low periods.
- R9: During reset, all strobes and the write enable are high, `req_ready_o` is high and `rsp_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cbr_mode_i | input | 1 | Refresh style: 0 row-strobe-only, 1 column-before-row |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Host request accepted this cycle when high with valid |
| req_addr_i | input | 12 | Host word address |
| req_we_i | input | 1 | Host write flag |
| req_wdata_i | input | 1 | Host write data bit |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 1 | Read data bit |
| dram_addr_o | output | 6 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_din_o | output | 1 | Data bit to the memory |
| dram_dout_i | input | 1 | Data bit from the memory |

## Verification
The assertions take `cbr_mode_i` as constant outside reset. If the mode changed during a refresh, the column-first check would see a sequence that is legal for the old mode. The stimulus therefore sets the mode only while reset is asserted, and runs a full sweep in row-strobe mode followed by a sparse sweep in column-first mode. The host holds each request until it is accepted and waits for the previous access to finish before raising the next one. This keeps the bench's notion of the current address aligned with the strobe edges that the memory model decodes.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,   // row on bus, strobes high
    ST_RCD,   // row strobe low
    ST_COL,   // column on bus, write enable set
    ST_CAS,   // column strobe low
    ST_RUP,   // row strobe up, column still low
    ST_PRE,   // precharge
    ST_RROW,  // refresh row on bus
    ST_RRAS,  // refresh row strobe low
    ST_CCAS,  // column-first refresh: column low
    ST_CRAS   // column-first refresh: both low
  } ctrl_st_e;
endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int PH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [PH_W-1:0] load_val_i,
  output logic            done_o
);
  logic [PH_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/ref_timer.sv
module ref_timer #(
  parameter int REF_INTERVAL = 3125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int CNT_W = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  assign expire = (cnt_q == CNT_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      cnt_q  <= expire ? '0 : cnt_q + 1'b1;
      pend_o <= expire | (pend_o & ~ack_i);
    end
  end
endmodule

// File: rtl/ref_row_ctr.sv
module ref_row_ctr #(
  parameter int ROW_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_o <= '0;
    else if (inc_i)  row_o <= row_o + 1'b1;  // natural wrap at all-ones
  end
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int MUX_W        = 6,
  parameter int REF_INTERVAL = 3125,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RAS        = 4,
  parameter int T_RP         = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cbr_mode_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [2*MUX_W-1:0] req_addr_i,
  input  logic               req_we_i,
  input  logic               req_wdata_i,
  output logic               rsp_valid_o,
  output logic               rsp_rdata_o,
  output logic [MUX_W-1:0]   dram_addr_o,
  output logic               dram_ras_no,
  output logic               dram_cas_no,
  output logic               dram_we_no,
  output logic               dram_din_o,
  input  logic               dram_dout_i
);
  localparam int ADDR_W = 2 * MUX_W;
  localparam int T_M1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int T_M2   = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int T_MAX  = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int PH_W   = $clog2(T_MAX + 1);

  ctrl_st_e          st_q, st_d;
  logic              ph_done, ph_load;
  logic [PH_W-1:0]   ph_val;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q, wd_q;
  logic              ref_pend, ref_ack, row_inc;
  logic [MUX_W-1:0]  ref_row;
  logic              accept;
  logic              rsp_q, rd_q;
  logic [MUX_W-1:0]  row_a, col_a;

  assign row_a = addr_q[ADDR_W-1:MUX_W];
  assign col_a = addr_q[MUX_W-1:0];

  function automatic logic [PH_W-1:0] dur_m1(ctrl_st_e s);
    case (s)
      ST_RCD:           return PH_W'(T_RCD - 1);
      ST_CAS:           return PH_W'(T_CAS - 1);
      ST_RRAS, ST_CRAS: return PH_W'(T_RAS - 1);
      ST_PRE:           return PH_W'(T_RP - 1);
      default:          return '0;
    endcase
  endfunction

  ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_ref_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ack_i (ref_ack),
    .pend_o(ref_pend)
  );

  ref_row_ctr #(.ROW_W(MUX_W)) u_row_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (row_inc),
    .row_o (ref_row)
  );

  phase_timer #(.PH_W(PH_W)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ph_load),
    .load_val_i(ph_val),
    .done_o    (ph_done)
  );

  assign req_ready_o = (st_q == ST_IDLE) && !ref_pend;
  assign accept      = req_ready_o && req_valid_i;
  assign ref_ack     = (st_q == ST_IDLE) && ref_pend;
  assign row_inc     = (st_q == ST_RRAS) && ph_done;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (ref_pend)         st_d = cbr_mode_i ? ST_CCAS : ST_RROW;
               else if (req_valid_i) st_d = ST_ROW;
      ST_ROW:  st_d = ST_RCD;
      ST_RCD:  if (ph_done) st_d = ST_COL;
      ST_COL:  st_d = ST_CAS;
      ST_CAS:  if (ph_done) st_d = ST_RUP;
      ST_RUP:  st_d = ST_PRE;
      ST_PRE:  if (ph_done) st_d = ST_IDLE;
      ST_RROW: st_d = ST_RRAS;
      ST_RRAS: if (ph_done) st_d = ST_PRE;
      ST_CCAS: st_d = ST_CRAS;
      ST_CRAS: if (ph_done) st_d = ST_PRE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign ph_load = (st_d != st_q);
  assign ph_val  = dur_m1(st_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      we_q   <= 1'b0;
      wd_q   <= 1'b0;
      rsp_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q <= req_addr_i;
        we_q   <= req_we_i;
        wd_q   <= req_wdata_i;
      end
      rsp_q <= (st_q == ST_CAS) && ph_done && !we_q;
      if ((st_q == ST_CAS) && ph_done && !we_q) rd_q <= dram_dout_i;
    end
  end

  // pin decode from registered state
  always_comb begin
    dram_ras_no = !(st_q inside {ST_RCD, ST_COL, ST_CAS, ST_RRAS, ST_CRAS});
    dram_cas_no = !(st_q inside {ST_CAS, ST_RUP, ST_CCAS, ST_CRAS});
    dram_we_no  = !(we_q && (st_q inside {ST_COL, ST_CAS, ST_RUP}));
    case (st_q)
      ST_ROW, ST_RCD:         dram_addr_o = row_a;
      ST_COL, ST_CAS, ST_RUP: dram_addr_o = col_a;
      ST_RROW, ST_RRAS:       dram_addr_o = ref_row;
      default:                dram_addr_o = '0;
    endcase
  end

  assign dram_din_o  = wd_q;
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rd_q;
endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
  parameter int MUX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cbr_mode_i,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic [MUX_W-1:0] dram_addr_o,
  input logic             dram_ras_no,
  input logic             dram_cas_no,
  input logic             dram_we_no,
  input logic [MUX_W-1:0] ref_row,
  input logic             row_inc
);
  AST_ROW_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) && dram_cas_no |-> $stable(dram_addr_o)); // R1
  AST_COL_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) && !dram_ras_no |-> $stable(dram_addr_o)); // R1
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R2
  AST_WE_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) |-> $stable(dram_we_no)); // R3
  AST_WE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no && $past(!dram_cas_no) |-> $stable(dram_we_no)); // R3
  AST_RAS_UP_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_cas_no) |-> dram_ras_no); // R3
  AST_ROW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_inc && (ref_row == '1) |=> ref_row == '0); // R5
  AST_ROR_CAS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cbr_mode_i && $fell(dram_ras_no) |-> dram_cas_no); // R5
  AST_CAS_FIRST_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) && dram_ras_no |-> cbr_mode_i); // R6
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> dram_ras_no && dram_cas_no); // R7
endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(.MUX_W(MUX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cbr_mode_i (cbr_mode_i),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .dram_addr_o(dram_addr_o),
  .dram_ras_no(dram_ras_no),
  .dram_cas_no(dram_cas_no),
  .dram_we_no (dram_we_no),
  .ref_row    (ref_row),
  .row_inc    (row_inc)
);

// File: tb/tb_dram_refresh_ctrl.sv
module tb_dram_refresh_ctrl;
  localparam int RI = 150, TRCD = 2, TCAS = 2, TRAS = 4, TRP = 3, SLACK = 14;

  logic clk = 1'b0, rst_n = 1'b0, cbr = 1'b0;
  logic vld = 1'b0, we = 1'b0, wd = 1'b0;
  logic [11:0] addr = '0;
  logic ready, rsp_valid, rdata, ras_n, cas_n, we_n, din, dout;
  logic [5:0] daddr;

  dram_refresh_ctrl #(.MUX_W(6), .REF_INTERVAL(RI), .T_RCD(TRCD), .T_CAS(TCAS),
                      .T_RAS(TRAS), .T_RP(TRP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cbr_mode_i(cbr),
    .req_valid_i(vld), .req_ready_o(ready), .req_addr_i(addr),
    .req_we_i(we), .req_wdata_i(wd),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rdata),
    .dram_addr_o(daddr), .dram_ras_no(ras_n), .dram_cas_no(cas_n),
    .dram_we_no(we_n), .dram_din_o(din), .dram_dout_i(dout));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pat(input logic [11:0] a, input bit s);
    return (^(a ^ (a >> 5))) ^ s ^ a[2];
  endfunction

  // memory model and pin monitor
  bit mem [4096];
  logic [5:0] row_l = '0, col_l = '0, exp_row = '0;
  logic pr, pc;
  int t_rf, t_rr, t_cf, last_ref, n_ror, n_cbr, n_acc, acc1, acc2, n_rsp;
  bit saw_cas, in_cbr, have_rr;
  int n_ref;
  logic [11:0] cur_addr;
  bit cur_we, last_rd;

  assign dout = mem[{row_l, col_l}];

  task automatic ref_note(input int t);
    chk(ready == 1'b0, "R7 ready low around refresh", int'(ready), 0);
    if (n_ref >= 2) begin
      if (n_acc == acc2) chk(t - last_ref == RI, "R4 idle refresh spacing", t - last_ref, RI);
      else chk((t - last_ref >= RI - SLACK) && (t - last_ref <= RI + SLACK),
               "R4 R7 loaded refresh spacing", t - last_ref, RI);
    end
    last_ref = t;
    acc2 = acc1;
    acc1 = n_acc;
    n_ref++;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      pr = 1'b1; pc = 1'b1; have_rr = 0; exp_row = '0; in_cbr = 0; saw_cas = 0; n_ref = 0;
    end else begin
      if (rsp_valid) begin n_rsp++; last_rd = rdata; end
      if (pr && !ras_n) begin
        if (have_rr) chk(cyc - t_rr >= TRP, "R8 row strobe precharge", cyc - t_rr, TRP);
        t_rf = cyc; saw_cas = 0;
        if (cas_n) begin
          row_l = daddr; in_cbr = 0;
        end else begin
          in_cbr = 1; n_cbr++;
          chk(cbr == 1'b1, "R6 column-first refresh in mode 1", int'(cbr), 1);
          chk(daddr == '0, "R6 column-first refresh address", int'(daddr), 0);
          chk(cyc - t_cf == 1, "R6 column leads row by one", cyc - t_cf, 1);
          ref_note(cyc);
        end
      end
      if (pc && !cas_n) begin
        t_cf = cyc;
        if (!ras_n) begin
          saw_cas = 1; col_l = daddr;
          chk({row_l, daddr} == cur_addr, "R1 row/column split", int'({row_l, daddr}), int'(cur_addr));
          chk(cyc - t_rf == TRCD + 1, "R8 row-to-column delay", cyc - t_rf, TRCD + 1);
          chk(we_n == !cur_we, "R3 write enable before column", int'(we_n), int'(!cur_we));
          if (cur_we) mem[{row_l, daddr}] = din;
        end else begin
          chk(cbr == 1'b1, "R6 column-first only in mode 1", int'(cbr), 1);
        end
      end
      if (!pc && !cas_n && saw_cas && cur_we)
        chk(we_n == 1'b0, "R3 write enable held", int'(we_n), 0);
      if (!pr && ras_n) begin
        if (saw_cas) chk(cas_n == 1'b0, "R3 row strobe rises first", int'(cas_n), 0);
        else if (in_cbr) chk(cyc - t_rf == TRAS, "R6 refresh row low width", cyc - t_rf, TRAS);
        else begin
          n_ror++;
          chk(cbr == 1'b0, "R5 row-only refresh in mode 0", int'(cbr), 0);
          chk(row_l == exp_row, "R5 refresh row counter", int'(row_l), int'(exp_row));
          chk(cyc - t_rf == TRAS, "R5 refresh row low width", cyc - t_rf, TRAS);
          exp_row = exp_row + 1'b1;
          ref_note(t_rf);
        end
        t_rr = cyc; have_rr = 1;
      end
      if (!pc && cas_n && saw_cas)
        chk(cyc - t_cf == TCAS + 1, "R8 column low width", cyc - t_cf, TCAS + 1);
      pr = ras_n; pc = cas_n;
    end
  end

  task automatic host(input logic [11:0] a, input bit w, input bit d);
    @(negedge clk);
    addr = a; we = w; wd = d; vld = 1'b1; cur_addr = a; cur_we = w;
    while (!ready) @(negedge clk);
    @(negedge clk);
    vld = 1'b0; n_acc++;
    while (!ready) @(negedge clk);
  endtask

  task automatic sweep(input int step, input bit s);
    for (int a = 0; a < 4096; a += step) host(12'(a), 1'b1, pat(12'(a), s));
    for (int a = 0; a < 4096; a += step) begin
      int r0;
      r0 = n_rsp;
      host(12'(a), 1'b0, 1'b0);
      chk(n_rsp == r0 + 1, "R2 one response per read", n_rsp - r0, 1);
      chk(last_rd == pat(12'(a), s), "R2 read data", int'(last_rd), int'(pat(12'(a), s)));
    end
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    summary();
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n, "R9 strobes high in reset", int'({ras_n, cas_n}), 3);
    chk(we_n == 1'b1, "R9 write enable high in reset", int'(we_n), 1);
    chk(ready == 1'b1, "R9 ready in reset", int'(ready), 1);
    chk(rsp_valid == 1'b0, "R9 no response in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    // writes alone must not respond
    r0 = n_rsp;
    host(12'hABC, 1'b1, 1'b1);
    host(12'h3C5, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk(n_rsp == r0, "R2 no response on write", n_rsp - r0, 0);
    sweep(1, 1'b0);
    repeat (5 * RI) @(negedge clk);
    chk(n_ror >= 65, "R5 counter wrapped past 63", n_ror, 65);
    chk(n_cbr == 0, "R6 no column-first refresh in mode 0", n_cbr, 0);
    // second pass: column-first refresh
    @(negedge clk);
    rst_n = 1'b0; cbr = 1'b1;
    n_ror = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep(7, 1'b1);
    repeat (5 * RI) @(negedge clk);
    chk(n_cbr > 5, "R6 column-first refreshes seen", n_cbr, 6);
    chk(n_ror == 0, "R6 no row-only refresh in mode 1", n_ror, 0);
    summary();
  end
endmodule